// File: doc/BRIEF.md
# Multi-thread gate control scheduler

This block drives transmit gate masks for every priority queue of several egress ports. All ports share one gate control list. Several execution threads step through that list at the same time. Each thread has its own first entry, last entry and start time. A thread stays idle until a free-running local time counter reaches its start time. From then on it runs entries one after another. Each entry keeps its gate pattern for a programmed number of ticks. The thread then loops from its last entry back to its first one.

The list lives in a register array. It can be loaded only while the block is held in reset. Releasing reset makes the loaded list the schedule in effect, and there is no second staged schedule. Each running thread drives the port named in its current entry. A port with no running thread keeps all its gates open. A gate opens for its whole interval whatever the length of the frame waiting behind it. The block raises a sticky flag if a list write arrives while the schedule is running. It raises a second sticky flag if two running threads sit on the same list entry in the same cycle.

Top module: `gcl_sched_top`

## Requirements
- R1: `local_time` is 0 while `rst_n` is low. In every clock cycle after reset release it increases by exactly 1.
- R2: A list write (`wr_en`, `wr_addr`, `wr_data`) is stored only while `rst_n` is low. After release the stored list is the one in effect. With the default parameters an entry is laid out as follows:
  - bit 0 is the end-of-segment marker;
  - bits 2:1 are the port;
  - bits 18:3 are the interval in ticks;
  - bits 50:19 are the gate mask, where bit port*8+priority opens that queue.
- R3: A write with `wr_en` high while `rst_n` is high leaves the list unchanged. It sets `wr_rejected` from the next cycle on. The flag stays set until reset.
- R4: Thread t runs only if `thr_enable[t]` is 1.
  - Its first entry is `thr_first[t*4+:4]` and its last entry is `thr_last[t*4+:4]`.
  - Its start time is `thr_start[t*32+:32]`.
  - It starts in the cycle where `local_time` equals its start time S.
  - The gates show its first entry from the cycle where `local_time` equals S+2.
- R5: A running thread holds each entry for max(interval,1) cycles and then moves on. An interval of 0 or 1 keeps the gate open for one cycle, with no allowance for frame length.
- R6: A thread moves from its last entry, or from any entry whose end-of-segment marker is 1, back to its first entry. Otherwise it goes to the next index, wrapping from the top index to 0.
- R7: A running thread drives the port named in its current entry. That port's 8 gates take mask bits [port*8+:8]. When several running threads name the same port, the lowest-numbered thread wins.
- R8: The gates of a port with no running thread are all 1 (open). During reset `gate_open` is all 1.
- R9: `conflict` becomes 1 in the cycle after two running threads share the same list index. It stays 1 until reset and is 0 after reset.
- R10: A thread with its enable bit at 0 never drives a gate, whatever its start time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low scheduler reset; the list is writable only while low |
| wr_en | input | 1 | List write strobe |
| wr_addr | input | IDX_W (4) | List entry index to write |
| wr_data | input | ENTRY_W (51) | Entry value |
| thr_enable | input | N_THREADS (8) | Per-thread enable |
| thr_first | input | N_THREADS*IDX_W | Per-thread first entry index |
| thr_last | input | N_THREADS*IDX_W | Per-thread last entry index |
| thr_start | input | N_THREADS*TIME_W | Per-thread start time against the local counter |
| local_time | output | TIME_W (32) | Free-running local time counter |
| gate_open | output | N_PORTS*N_PRIO (32) | Gate state, bit port*8+priority |
| wr_rejected | output | 1 | Sticky: a write was attempted while running |
| conflict | output | 1 | Sticky: two threads ran the same entry at once |

## Verification
The properties run on every cycle and check these rules:
- the time counter steps by one after reset;
- both sticky flags stay set once raised;
- a write while running raises the rejected flag;
- the conflict flag stays low while at most one thread runs;
- all gates reopen when no thread runs.

The bench's scenarios show what a property cannot see:
- the exact cycle in which each thread starts;
- how long each entry is held, including zero and one-tick intervals;
- wrapping at the last index and at the end-of-segment marker;
- lowest-thread priority on a shared port, a disabled thread staying silent, and a rejected write leaving the schedule untouched;
- a reloaded list taking effect, and the cycle in which a conflict is flagged.

// File: rtl/gcl_sched_pkg.sv
package gcl_sched_pkg;
   typedef enum logic {THR_IDLE = 1'b0, THR_RUN = 1'b1} thr_state_e;

   function automatic int unsigned idx_bits(int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/gcl_list_store.sv
module gcl_list_store #(
   parameter int unsigned DEPTH   = 16,
   parameter int unsigned N_THR   = 8,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned PORT_W  = 2,
   parameter int unsigned IVL_W   = 16,
   parameter int unsigned MASK_W  = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_addr,
   input  logic [MASK_W+IVL_W+PORT_W:0] wr_data,
   input  logic [N_THR*IDX_W-1:0]    cur_idx,
   input  logic [N_THR*IDX_W-1:0]    nxt_idx,
   output logic [N_THR*MASK_W-1:0]   cur_mask,
   output logic [N_THR*PORT_W-1:0]   cur_port,
   output logic [N_THR-1:0]          cur_end,
   output logic [N_THR*IVL_W-1:0]    nxt_ivl,
   output logic                      wr_rejected
);
   localparam int unsigned ENTRY_W  = MASK_W + IVL_W + PORT_W + 1;
   localparam int unsigned PORT_LSB = 1;
   localparam int unsigned IVL_LSB  = PORT_LSB + PORT_W;
   localparam int unsigned MASK_LSB = IVL_LSB + IVL_W;

   logic [ENTRY_W-1:0] mem [DEPTH];

   // loads happen only while the scheduler is held in reset
   always_ff @(posedge clk) begin
      if (!rst_n && wr_en && (int'(wr_addr) < DEPTH))
         mem[wr_addr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_rejected <= 1'b0;
      else if (wr_en)
         wr_rejected <= 1'b1;
   end

   for (genvar t = 0; t < N_THR; t++) begin : g_rd
      logic [IDX_W-1:0]   ci, ni;
      logic [ENTRY_W-1:0] ce, ne;
      assign ci = cur_idx[t*IDX_W +: IDX_W];
      assign ni = nxt_idx[t*IDX_W +: IDX_W];
      assign ce = (int'(ci) < DEPTH) ? mem[ci] : '0;
      assign ne = (int'(ni) < DEPTH) ? mem[ni] : '0;
      assign cur_mask[t*MASK_W +: MASK_W] = ce[MASK_LSB +: MASK_W];
      assign cur_port[t*PORT_W +: PORT_W] = ce[PORT_LSB +: PORT_W];
      assign cur_end[t]                   = ce[0];
      assign nxt_ivl[t*IVL_W +: IVL_W]    = ne[IVL_LSB +: IVL_W];
   end
endmodule

// File: rtl/gcl_thread.sv
module gcl_thread
   import gcl_sched_pkg::*;
#(
   parameter int unsigned DEPTH  = 16,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned IVL_W  = 16,
   parameter int unsigned TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [IDX_W-1:0]  first_idx,
   input  logic [IDX_W-1:0]  last_idx,
   input  logic [TIME_W-1:0] start_time,
   input  logic [TIME_W-1:0] now,
   input  logic              cur_end,
   input  logic [IVL_W-1:0]  nxt_ivl,
   output logic              active,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [IDX_W-1:0]  nxt_idx
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(DEPTH - 1);

   thr_state_e       state;
   logic [IVL_W-1:0] remain;
   logic             step;

   assign active = (state == THR_RUN);

   always_comb begin
      if (!active || cur_idx == last_idx || cur_end)
         nxt_idx = first_idx;
      else if (cur_idx == TOP_IDX)
         nxt_idx = '0;
      else
         nxt_idx = cur_idx + IDX_W'(1);
   end

   // entry expires when its tick count is used up (zero acts as one)
   assign step = (remain <= IVL_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= THR_IDLE;
         cur_idx <= '0;
         remain  <= '0;
      end else begin
         case (state)
            THR_IDLE: begin
               if (enable && now == start_time) begin
                  state   <= THR_RUN;
                  cur_idx <= nxt_idx;
                  remain  <= nxt_ivl;
               end
            end
            default: begin
               if (step) begin
                  cur_idx <= nxt_idx;
                  remain  <= nxt_ivl;
               end else begin
                  remain  <= remain - IVL_W'(1);
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/gcl_conflict.sv
module gcl_conflict #(
   parameter int unsigned N_THR = 8,
   parameter int unsigned IDX_W = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_THR-1:0]       active,
   input  logic [N_THR*IDX_W-1:0] idx,
   output logic                   conflict
);
   logic hit;

   if (N_THR < 2) begin : g_single
      assign hit = 1'b0;
   end else begin : g_pairs
      always_comb begin
         hit = 1'b0;
         for (int i = 0; i < N_THR; i++) begin
            for (int j = i + 1; j < N_THR; j++) begin
               if (active[i] && active[j] &&
                   idx[i*IDX_W +: IDX_W] == idx[j*IDX_W +: IDX_W])
                  hit = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         conflict <= 1'b0;
      else if (hit)
         conflict <= 1'b1;
   end
endmodule

// File: rtl/gcl_port_mux.sv
module gcl_port_mux #(
   parameter int unsigned N_THR   = 8,
   parameter int unsigned N_PORTS = 4,
   parameter int unsigned N_PRIO  = 8,
   parameter int unsigned PORT_W  = 2
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [N_THR-1:0]                    active,
   input  logic [N_THR*PORT_W-1:0]             port,
   input  logic [N_THR*N_PORTS*N_PRIO-1:0]     mask,
   output logic [N_PORTS*N_PRIO-1:0]           gate_open
);
   localparam int unsigned MASK_W = N_PORTS * N_PRIO;

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      logic [N_PRIO-1:0] sel;

      // scan from the top so the lowest-numbered thread overrides
      always_comb begin
         sel = '1;
         for (int t = N_THR - 1; t >= 0; t--) begin
            if (active[t] && port[t*PORT_W +: PORT_W] == PORT_W'(p))
               sel = mask[t*MASK_W + p*N_PRIO +: N_PRIO];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            gate_open[p*N_PRIO +: N_PRIO] <= '1;
         else
            gate_open[p*N_PRIO +: N_PRIO] <= sel;
      end
   end
endmodule

// File: rtl/gcl_sched_top.sv
module gcl_sched_top
   import gcl_sched_pkg::*;
#(
   parameter int unsigned N_THREADS  = 8,
   parameter int unsigned N_PORTS    = 4,
   parameter int unsigned N_PRIO     = 8,
   parameter int unsigned LIST_DEPTH = 16,
   parameter int unsigned IVL_W      = 16,
   parameter int unsigned TIME_W     = 32,
   localparam int unsigned IDX_W     = idx_bits(LIST_DEPTH),
   localparam int unsigned PORT_W    = idx_bits(N_PORTS),
   localparam int unsigned MASK_W    = N_PORTS * N_PRIO,
   localparam int unsigned ENTRY_W   = MASK_W + IVL_W + PORT_W + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_addr,
   input  logic [ENTRY_W-1:0]            wr_data,
   input  logic [N_THREADS-1:0]          thr_enable,
   input  logic [N_THREADS*IDX_W-1:0]    thr_first,
   input  logic [N_THREADS*IDX_W-1:0]    thr_last,
   input  logic [N_THREADS*TIME_W-1:0]   thr_start,
   output logic [TIME_W-1:0]             local_time,
   output logic [MASK_W-1:0]             gate_open,
   output logic                          wr_rejected,
   output logic                          conflict
);
   if (N_THREADS < 1 || N_PORTS < 1 || N_PRIO < 1 || LIST_DEPTH < 2 ||
       IVL_W < 1 || TIME_W < 2) begin : g_bad_cfg
      $error("gcl_sched_top: parameter out of range");
   end

   logic [N_THREADS-1:0]        thr_active;
   logic [N_THREADS*IDX_W-1:0]  thr_cur_idx;
   logic [N_THREADS*IDX_W-1:0]  thr_nxt_idx;
   logic [N_THREADS*MASK_W-1:0] thr_mask;
   logic [N_THREADS*PORT_W-1:0] thr_port;
   logic [N_THREADS-1:0]        thr_end;
   logic [N_THREADS*IVL_W-1:0]  thr_nxt_ivl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         local_time <= '0;
      else
         local_time <= local_time + TIME_W'(1);
   end

   gcl_list_store #(
      .DEPTH (LIST_DEPTH), .N_THR (N_THREADS), .IDX_W (IDX_W),
      .PORT_W(PORT_W),     .IVL_W (IVL_W),     .MASK_W(MASK_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .cur_idx    (thr_cur_idx),
      .nxt_idx    (thr_nxt_idx),
      .cur_mask   (thr_mask),
      .cur_port   (thr_port),
      .cur_end    (thr_end),
      .nxt_ivl    (thr_nxt_ivl),
      .wr_rejected(wr_rejected)
   );

   for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
      gcl_thread #(
         .DEPTH(LIST_DEPTH), .IDX_W(IDX_W), .IVL_W(IVL_W), .TIME_W(TIME_W)
      ) u_thread (
         .clk       (clk),
         .rst_n     (rst_n),
         .enable    (thr_enable[t]),
         .first_idx (thr_first[t*IDX_W +: IDX_W]),
         .last_idx  (thr_last[t*IDX_W +: IDX_W]),
         .start_time(thr_start[t*TIME_W +: TIME_W]),
         .now       (local_time),
         .cur_end   (thr_end[t]),
         .nxt_ivl   (thr_nxt_ivl[t*IVL_W +: IVL_W]),
         .active    (thr_active[t]),
         .cur_idx   (thr_cur_idx[t*IDX_W +: IDX_W]),
         .nxt_idx   (thr_nxt_idx[t*IDX_W +: IDX_W])
      );
   end

   gcl_conflict #(.N_THR(N_THREADS), .IDX_W(IDX_W)) u_conflict (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (thr_active),
      .idx     (thr_cur_idx),
      .conflict(conflict)
   );

   gcl_port_mux #(
      .N_THR(N_THREADS), .N_PORTS(N_PORTS), .N_PRIO(N_PRIO), .PORT_W(PORT_W)
   ) u_mux (
      .clk      (clk),
      .rst_n    (rst_n),
      .active   (thr_active),
      .port     (thr_port),
      .mask     (thr_mask),
      .gate_open(gate_open)
   );
endmodule

// File: rtl/gcl_sched_checker.sv
module gcl_sched_checker #(
   parameter int unsigned N_THREADS = 8,
   parameter int unsigned MASK_W    = 32,
   parameter int unsigned TIME_W    = 32
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 wr_en,
   input logic                 wr_rejected,
   input logic                 conflict,
   input logic [TIME_W-1:0]    local_time,
   input logic [MASK_W-1:0]    gate_open,
   input logic [N_THREADS-1:0] thr_active
);
   p_time_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> local_time == $past(local_time) + TIME_W'(1));

   p_reject_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> wr_rejected);

   p_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_rejected |=> wr_rejected);

   p_conflict_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      conflict |=> conflict);

   p_no_conflict_lone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (($countones(thr_active) < 2) && !conflict) |=> !conflict);

   p_idle_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_active == '0) |=> (gate_open == '1));
endmodule

bind gcl_sched_top gcl_sched_checker #(
   .N_THREADS(N_THREADS), .MASK_W(MASK_W), .TIME_W(TIME_W)
) u_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_rejected(wr_rejected),
   .conflict   (conflict),
   .local_time (local_time),
   .gate_open  (gate_open),
   .thr_active (thr_active)
);

// File: tb/gcl_sched_top_bench.sv
module gcl_sched_top_bench;
   localparam int NT = 8;
   localparam int NP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [3:0]    wr_addr = '0;
   logic [50:0]   wr_data = '0;
   logic [NT-1:0]    thr_enable;
   logic [NT*4-1:0]  thr_first;
   logic [NT*4-1:0]  thr_last;
   logic [NT*32-1:0] thr_start;
   logic [31:0]   local_time;
   logic [31:0]   gate_open;
   logic          wr_rejected;
   logic          conflict;

   logic [50:0] blist [16];
   logic        ben    [NT];
   logic [3:0]  bfirst [NT];
   logic [3:0]  blast  [NT];
   int          bstart [NT];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   always_comb begin
      for (int t = 0; t < NT; t++) begin
         thr_enable[t]          = ben[t];
         thr_first[t*4 +: 4]    = bfirst[t];
         thr_last[t*4 +: 4]     = blast[t];
         thr_start[t*32 +: 32]  = bstart[t];
      end
   end

   gcl_sched_top u_gcl_sched_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .thr_enable(thr_enable), .thr_first(thr_first),
      .thr_last(thr_last), .thr_start(thr_start), .local_time(local_time),
      .gate_open(gate_open), .wr_rejected(wr_rejected), .conflict(conflict)
   );

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [50:0] mk(int port, int ivl, logic [7:0] slice, bit endm);
      logic [31:0] m;
      m = {4{8'h5A}};
      m[port*8 +: 8] = slice;
      return {m, ivl[15:0], port[1:0], endm};
   endfunction

   // list index a thread holds when local_time == T, or -1 if not yet running
   function automatic int exp_idx(int t, int T);
      int e;
      int idx;
      int d;
      if (!ben[t]) return -1;
      e = T - bstart[t] - 2;
      if (e < 0) return -1;
      idx = bfirst[t];
      while (1) begin
         d = (blist[idx][18:3] == 0) ? 1 : int'(blist[idx][18:3]);
         if (e < d) return idx;
         e -= d;
         if (idx == blast[t] || blist[idx][0]) idx = bfirst[t];
         else if (idx == 15) idx = 0;
         else idx++;
      end
      return -1;
   endfunction

   function automatic logic [7:0] exp_gate(int p, int T);
      int i;
      for (int t = 0; t < NT; t++) begin
         i = exp_idx(t, T);
         if (i >= 0 && int'(blist[i][2:1]) == p)
            return blist[i][19 + p*8 +: 8];
      end
      return 8'hFF;
   endfunction

   task automatic load_list();
      for (int a = 0; a < 16; a++) begin
         @(negedge clk);
         wr_en = 1'b1; wr_addr = a[3:0]; wr_data = blist[a];
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_reset();
      chk("R8 reset gates", 64'(gate_open), 64'hFFFF_FFFF);
      chk("R1 reset time", 64'(local_time), 64'd0);
      chk("R3 reset wr_rejected", 64'(wr_rejected), 64'd0);
      chk("R9 reset conflict", 64'(conflict), 64'd0);
   endtask

   initial begin
      for (int a = 0; a < 16; a++) blist[a] = mk(3, 1, 8'h00, 1'b0);
      for (int t = 0; t < NT; t++) begin
         ben[t] = 1'b0; bfirst[t] = '0; blast[t] = '0; bstart[t] = 0;
      end
      // thread 0 on port 0: three entries, wraps at last index
      blist[0]  = mk(0, 3, 8'h01, 1'b0);
      blist[1]  = mk(0, 1, 8'h02, 1'b0);
      blist[2]  = mk(0, 2, 8'h04, 1'b0);
      // thread 1 on port 1: wraps at end marker before its last index
      blist[4]  = mk(1, 2, 8'h10, 1'b0);
      blist[5]  = mk(1, 1, 8'h20, 1'b1);
      blist[6]  = mk(1, 1, 8'h40, 1'b0);
      // thread 2 on port 2: zero and one tick intervals
      blist[8]  = mk(2, 0, 8'h81, 1'b0);
      blist[9]  = mk(2, 1, 8'h18, 1'b0);
      // thread 3 on port 0, outranked by thread 0 once it runs
      blist[10] = mk(0, 5, 8'hA0, 1'b0);
      // disabled thread 4 on port 3
      blist[12] = mk(3, 2, 8'h00, 1'b0);
      ben[0] = 1; bfirst[0] = 0;  blast[0] = 2;  bstart[0] = 5;
      ben[1] = 1; bfirst[1] = 4;  blast[1] = 7;  bstart[1] = 10;
      ben[2] = 1; bfirst[2] = 8;  blast[2] = 9;  bstart[2] = 0;
      ben[3] = 1; bfirst[3] = 10; blast[3] = 10; bstart[3] = 3;
      ben[4] = 0; bfirst[4] = 12; blast[4] = 12; bstart[4] = 0;

      rst_n = 1'b0;
      load_list();
      #1;
      check_reset();
      @(negedge clk);
      rst_n = 1'b1;

      for (int T = 0; T <= 60; T++) begin
         #1;
         chk("R1 local_time", 64'(local_time), 64'(T));
         chk((T < 9) ? "R4 port0 start" : "R7 port0 priority",
             64'(gate_open[7:0]), 64'(exp_gate(0, T)));
         chk("R6 port1 wrap", 64'(gate_open[15:8]), 64'(exp_gate(1, T)));
         chk("R5 port2 short", 64'(gate_open[23:16]), 64'(exp_gate(2, T)));
         chk("R10 port3 disabled", 64'(gate_open[31:24]), 64'(exp_gate(3, T)));
         chk("R9 no conflict", 64'(conflict), 64'd0);
         if (T <= 30) chk("R3 wr_rejected low", 64'(wr_rejected), 64'd0);
         else         chk("R3 wr_rejected set", 64'(wr_rejected), 64'd1);
         if (T == 30) begin
            wr_en = 1'b1; wr_addr = 4'd9; wr_data = mk(2, 7, 8'h00, 1'b1);
         end
         if (T == 31) wr_en = 1'b0;
         @(negedge clk);
      end

      // reload during reset: two threads on the same entry
      rst_n = 1'b0;
      for (int t = 0; t < NT; t++) ben[t] = 1'b0;
      blist[0] = mk(1, 2, 8'h3C, 1'b1);
      ben[0] = 1; bfirst[0] = 0; blast[0] = 0; bstart[0] = 4;
      ben[1] = 1; bfirst[1] = 0; blast[1] = 0; bstart[1] = 4;
      load_list();
      #1;
      check_reset();
      @(negedge clk);
      rst_n = 1'b1;

      for (int T = 0; T <= 20; T++) begin
         #1;
         for (int p = 0; p < NP; p++)
            chk("R2 reloaded list", 64'(gate_open[p*8 +: 8]), 64'(exp_gate(p, T)));
         chk("R9 conflict flag", 64'(conflict), (T >= 6) ? 64'd1 : 64'd0);
         chk("R3 wr_rejected cleared", 64'(wr_rejected), 64'd0);
         @(negedge clk);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule